// File: doc/BRIEF.md
# UART Interrupt Combiner with Receive Character Timeout

This block gathers the event conditions of a UART into one interrupt request line and a small identity code that the host reads to find the cause. It watches the receive FIFO fill level against a selectable threshold, holds the receive error flags, tracks when the transmit FIFO drains, and runs its own character-timeout counter. That counter measures how long data has sat in the receive FIFO without being touched.

Each of the four causes has its own enable bit. Only enabled causes are considered. The identity code always names the single highest-priority enabled cause that is pending. The request line is high whenever any enabled cause is pending. Both outputs come from flops, so the host sees no combinational glitches.

Top module: `uart_irq_ctrl`

## Requirements
- R1: After reset, `irq` is 0 and `irq_id` is 0 (none pending), and the drained-transmit cause stays idle even though `tx_empty` is high out of reset.
- R2: Identity codes are: 0 none, 1 receive error, 2 fill threshold, 3 receive timeout, 4 transmit drained. When several enabled causes are pending, `irq_id` reports the one with the lowest code.
- R3: The enable mask maps bit 0 to receive error, bit 1 to fill threshold, bit 2 to receive timeout and bit 3 to transmit drained. A cause whose bit is 0 never appears in `irq_id` and never raises `irq`.
- R4: `irq` is 1 exactly when `irq_id` is not 0. Both outputs are registered and follow their inputs one clock later.
- R5: The fill-threshold cause is pending while `rx_level` is at least the threshold chosen by `trig_sel`: 0 selects 1, 1 selects 4, 2 selects 8 and 3 selects 14.
- R6: The receive error cause is pending while `rx_err_parity` or `rx_err_frame` is high.
- R7: The timeout cause becomes pending once 44 `bit_tick` pulses have arrived since the last restart. It holds until the next restart, and 43 pulses are not enough.
- R8: The timeout counter restarts on `rx_byte_stb`, on `hold_rd_stb`, and in any cycle in which `rx_empty` is high. A restart also clears a pending timeout.
- R9: The transmit-drained cause is set when `tx_empty` goes from 0 to 1. It is cleared by `tx_wr_stb`, or by `id_rd_stb` while `irq_id` reports code 4.
- R10: An `id_rd_stb` while `irq_id` reports a code other than 4 leaves the transmit-drained cause pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_level | input | LVL_W (5) | Current receive FIFO occupancy |
| rx_empty | input | 1 | Receive FIFO holds nothing |
| tx_empty | input | 1 | Transmit FIFO holds nothing |
| rx_err_parity | input | 1 | Parity error flag for received data |
| rx_err_frame | input | 1 | Framing error flag for received data |
| rx_byte_stb | input | 1 | One-cycle pulse: a byte entered the receive FIFO |
| hold_rd_stb | input | 1 | One-cycle pulse: host read the receive holding register |
| bit_tick | input | 1 | One-cycle pulse per serial bit time |
| id_rd_stb | input | 1 | One-cycle pulse: host read the identity code |
| tx_wr_stb | input | 1 | One-cycle pulse: host wrote transmit data |
| en_mask | input | 4 | Per-cause enable bits |
| trig_sel | input | 2 | Fill threshold select |
| irq | output | 1 | Registered interrupt request |
| irq_id | output | 3 | Registered identity of the top pending cause |

## Verification
A wrong priority order or a wrong mask decode shows up on `irq_id` in the cycle after the inputs settle. The mask sweep with every cause pending exposes it for every enable pattern. A timeout counter that is off by one shows as a code 3 appearing one tick early or late, and the 43/44 tick boundary catches that. A transmit-drained flag that is set or cleared wrongly shows up two cycles after the triggering strobe or edge, because the flag and the output stage each add one register.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int SRC_N  = 4;
  localparam int SRC_ERR  = 0;
  localparam int SRC_TRIG = 1;
  localparam int SRC_TMO  = 2;
  localparam int SRC_TXE  = 3;
  localparam int ID_W   = 3;

  typedef enum logic [ID_W-1:0] {
    IID_NONE  = 3'd0,
    IID_RXERR = 3'd1,
    IID_TRIG  = 3'd2,
    IID_TMO   = 3'd3,
    IID_TXE   = 3'd4
  } irq_id_e;
endpackage

// File: rtl/irq_fill_cmp.sv
module irq_fill_cmp #(
  parameter int LVL_W = 5,
  parameter int THR0  = 1,
  parameter int THR1  = 4,
  parameter int THR2  = 8,
  parameter int THR3  = 14
) (
  input  logic [LVL_W-1:0] level,
  input  logic [1:0]       sel,
  output logic             hit
);
  logic [LVL_W-1:0] thr;

  always_comb begin
    unique case (sel)
      2'd0:    thr = LVL_W'(THR0);
      2'd1:    thr = LVL_W'(THR1);
      2'd2:    thr = LVL_W'(THR2);
      default: thr = LVL_W'(THR3);
    endcase
    hit = (level >= thr);
  end
endmodule

// File: rtl/irq_rx_timeout.sv
module irq_rx_timeout #(
  parameter int TMO_BITS = 44
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic tick,
  output logic expired
);
  localparam int CNT_W = $clog2(TMO_BITS + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TMO_BITS);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = restart | (tick & (cnt_q != LIMIT));
    cnt_d  = restart ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == LIMIT);
endmodule

// File: rtl/irq_txe_flag.sv
module irq_txe_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic fifo_empty,
  input  logic clr,
  output logic pend
);
  logic empty_q, pend_q, pend_d, rise;

  always_comb begin
    rise   = fifo_empty & ~empty_q;
    pend_d = pend_q;
    if (clr)  pend_d = 1'b0;
    if (rise) pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      empty_q <= 1'b1;
      pend_q  <= 1'b0;
    end else begin
      empty_q <= fifo_empty;
      pend_q  <= pend_d;
    end
  end

  assign pend = pend_q;
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
  import uart_irq_pkg::*;
(
  input  logic [SRC_N-1:0] active,
  output logic             any,
  output irq_id_e          id
);
  always_comb begin
    id  = IID_NONE;
    any = |active;
    for (int i = SRC_N - 1; i >= 0; i--) begin
      if (active[i]) id = irq_id_e'(ID_W'(i + 1));
    end
  end
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
#(
  parameter int LVL_W    = 5,
  parameter int TMO_BITS = 44
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] rx_level,
  input  logic             rx_empty,
  input  logic             tx_empty,
  input  logic             rx_err_parity,
  input  logic             rx_err_frame,
  input  logic             rx_byte_stb,
  input  logic             hold_rd_stb,
  input  logic             bit_tick,
  input  logic             id_rd_stb,
  input  logic             tx_wr_stb,
  input  logic [3:0]       en_mask,
  input  logic [1:0]       trig_sel,
  output logic             irq,
  output logic [2:0]       irq_id
);
  logic             trig_hit, tmo_exp, txe_pend, txe_clr, tmo_restart;
  logic [SRC_N-1:0] pend, active;
  logic             any_d, irq_q;
  irq_id_e          id_d, id_q;

  irq_fill_cmp #(.LVL_W(LVL_W)) u_fill (
    .level(rx_level), .sel(trig_sel), .hit(trig_hit)
  );

  assign tmo_restart = rx_byte_stb | hold_rd_stb | rx_empty;

  irq_rx_timeout #(.TMO_BITS(TMO_BITS)) u_tmo (
    .clk(clk), .rst_n(rst_n), .restart(tmo_restart),
    .tick(bit_tick), .expired(tmo_exp)
  );

  assign txe_clr = tx_wr_stb | (id_rd_stb & (id_q == IID_TXE));

  irq_txe_flag u_txe (
    .clk(clk), .rst_n(rst_n), .fifo_empty(tx_empty),
    .clr(txe_clr), .pend(txe_pend)
  );

  always_comb begin
    pend           = '0;
    pend[SRC_ERR]  = rx_err_parity | rx_err_frame;
    pend[SRC_TRIG] = trig_hit;
    pend[SRC_TMO]  = tmo_exp;
    pend[SRC_TXE]  = txe_pend;
    active         = pend & en_mask;
  end

  irq_prio_enc u_enc (.active(active), .any(any_d), .id(id_d));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
      id_q  <= IID_NONE;
    end else begin
      irq_q <= any_d;
      id_q  <= id_d;
    end
  end

  assign irq    = irq_q;
  assign irq_id = id_q;
endmodule

// File: rtl/uart_irq_ctrl_chk.sv
module uart_irq_ctrl_chk #(
  parameter int LVL_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic [LVL_W-1:0] rx_level,
  input logic             rx_err_parity,
  input logic             rx_err_frame,
  input logic [3:0]       en_mask,
  input logic             irq,
  input logic [2:0]       irq_id
);
  // R4
  irq_matches_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (irq_id != 3'd0));

  // R2
  id_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_id <= 3'd4);

  // R6
  err_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((rx_err_parity | rx_err_frame) && en_mask[0]) |=> (irq_id == 3'd1));

  // R5
  full_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_mask == 4'b0010 && rx_level >= LVL_W'(14)) |=> (irq_id == 3'd2));

  // R3
  all_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_mask == 4'b0000) |=> !irq);
endmodule

bind uart_irq_ctrl uart_irq_ctrl_chk #(.LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_level(rx_level),
  .rx_err_parity(rx_err_parity), .rx_err_frame(rx_err_frame),
  .en_mask(en_mask), .irq(irq), .irq_id(irq_id)
);

// File: tb/uart_irq_ctrl_tb.sv
module uart_irq_ctrl_tb;
  localparam int LVL_W = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [LVL_W-1:0] rx_level = '0;
  logic rx_empty = 1'b1, tx_empty = 1'b1;
  logic rx_err_parity = 1'b0, rx_err_frame = 1'b0;
  logic rx_byte_stb = 1'b0, hold_rd_stb = 1'b0, bit_tick = 1'b0;
  logic id_rd_stb = 1'b0, tx_wr_stb = 1'b0;
  logic [3:0] en_mask = '0;
  logic [1:0] trig_sel = '0;
  logic irq;
  logic [2:0] irq_id;

  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  uart_irq_ctrl #(.LVL_W(LVL_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .rx_level(rx_level), .rx_empty(rx_empty),
    .tx_empty(tx_empty), .rx_err_parity(rx_err_parity), .rx_err_frame(rx_err_frame),
    .rx_byte_stb(rx_byte_stb), .hold_rd_stb(hold_rd_stb), .bit_tick(bit_tick),
    .id_rd_stb(id_rd_stb), .tx_wr_stb(tx_wr_stb), .en_mask(en_mask),
    .trig_sel(trig_sel), .irq(irq), .irq_id(irq_id)
  );

  task automatic settle();
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_out(input string req, input int exp_id);
    chk(req, irq_id, exp_id);
    chk(req, irq, (exp_id != 0) ? 1 : 0);
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1'b1;
    @(negedge clk); s = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) pulse(bit_tick);
  endtask

  function automatic int thr_of(input int sel);
    return (sel == 0) ? 1 : (sel == 1) ? 4 : (sel == 2) ? 8 : 14;
  endfunction

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    en_mask = 4'b1111;
    settle();
    // R1 reset state, tx_empty high but no rising edge seen
    chk_out("R1", 0);

    // R5 sweep every threshold over every level
    en_mask = 4'b0010;
    for (int s = 0; s < 4; s++) begin
      for (int l = 0; l < 17; l++) begin
        trig_sel = 2'(s); rx_level = LVL_W'(l); rx_empty = (l == 0);
        settle();
        chk_out("R5", (l >= thr_of(s)) ? 2 : 0);
      end
    end

    // R6 each error flag alone
    en_mask = 4'b0001; rx_level = '0; rx_empty = 1'b1;
    rx_err_parity = 1'b1; settle(); chk_out("R6", 1);
    rx_err_parity = 1'b0; rx_err_frame = 1'b1; settle(); chk_out("R6", 1);
    rx_err_frame = 1'b0; settle(); chk_out("R6", 0);

    // R7 43 vs 44 ticks
    en_mask = 4'b0100; rx_level = 5'd1; rx_empty = 1'b0; trig_sel = 2'd3;
    pulse(rx_byte_stb);
    ticks(43); settle(); chk_out("R7", 0);
    ticks(1);  settle(); chk_out("R7", 3);
    ticks(5);  settle(); chk_out("R7", 3);
    // R8 restart sources
    pulse(hold_rd_stb); settle(); chk_out("R8", 0);
    ticks(44); settle(); chk_out("R8", 3);
    pulse(rx_byte_stb); settle(); chk_out("R8", 0);
    ticks(44); settle(); chk_out("R8", 3);
    @(negedge clk) rx_empty = 1'b1; rx_level = '0;
    settle(); chk_out("R8", 0);
    ticks(50); settle(); chk_out("R8", 0);

    // R9 set on drain edge, clear on id read
    en_mask = 4'b1000;
    @(negedge clk) tx_empty = 1'b0;
    @(negedge clk) tx_empty = 1'b1;
    settle(); chk_out("R9", 4);
    pulse(id_rd_stb); settle(); chk_out("R9", 0);
    // R9 clear by write
    @(negedge clk) tx_empty = 1'b0;
    @(negedge clk) tx_empty = 1'b1;
    settle(); chk_out("R9", 4);
    pulse(tx_wr_stb); settle(); chk_out("R9", 0);

    // R10 id read while error reported leaves drain cause pending
    en_mask = 4'b1001;
    @(negedge clk) tx_empty = 1'b0;
    @(negedge clk) tx_empty = 1'b1;
    rx_err_frame = 1'b1; settle(); chk_out("R10", 1);
    pulse(id_rd_stb);
    rx_err_frame = 1'b0; settle(); chk_out("R10", 4);

    // R2 R3 mask sweep with all four causes pending
    rx_err_parity = 1'b1; trig_sel = 2'd0; rx_level = 5'd3; rx_empty = 1'b0;
    pulse(rx_byte_stb); ticks(44);
    for (int m = 0; m < 16; m++) begin
      int e;
      en_mask = 4'(m);
      e = 0;
      for (int b = 3; b >= 0; b--) if (m[b]) e = b + 1;
      settle();
      chk_out((m == 15) ? "R2" : "R3", e);
    end
    // R4 irq follows id one clock after a change
    en_mask = 4'b0000; settle(); chk("R4", irq, 0);
    @(negedge clk) en_mask = 4'b0001;
    @(posedge clk); @(negedge clk);
    chk("R4", irq, 1); chk("R4", irq_id, 1);

    finish_run();
  end
endmodule